// File: doc/BRIEF.md
# Interrupt CPU Interface Register File

This block is the register window one processor uses to take and retire interrupts. A priority selector outside the block offers the most urgent pending interrupt as an ID and a priority. Software reads the acknowledge word to claim that interrupt. The read succeeds only if the offered interrupt is more urgent than the one already running. On success the block records which interrupt was running before, makes the new one running, and pulses an acknowledge strobe so that the selector can drop the pending state.

Software writes the completion word with an interrupt ID to retire the running interrupt. Running ID and running priority then return to the values they held when that interrupt was claimed, so nesting unwinds in order. The block also holds a priority mask, a binary point and an aliased binary point for software, and it has four read-only words that show the priority groups of all active interrupts.

Access uses a simple word-addressed bus. A request with `bus_valid` high is answered exactly one cycle later by `rsp_valid`, read data and an error flag. Lower numbers mean more urgent. ID 1023 means "no interrupt".

Top module: `irq_cpu_iface`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0xFF, the priority mask, binary point and aliased binary point are 0, and no acknowledge or completion strobe is high.
- R2: Word 1 is the priority mask and stores bits 7:0 of a write. Word 2 is the binary point and stores bits 2:0. Both read back zero-extended.
- R3: Word 7 is the aliased binary point. When REVISION is 2 or more, a write stores bits 2:0. Below 2 the write is ignored and the word reads 0.
- R4: A read of word 3 (acknowledge) returns 1023 and changes no state when any of these holds: the offered ID is 1023, the offered ID is not below NUM_IRQ, or the offered priority is greater than or equal to the running priority. No acknowledge strobe follows.
- R5: Any other read of word 3 returns the offered ID and makes it the running ID, with the offered priority as running priority. In the response cycle `ack_pulse` is high for one cycle, with `ack_id` equal to that ID.
- R6: A write to word 4 (completion) takes bits 9:0 as the ID. If that ID equals the running ID, and the running ID is not 1023, running ID and priority return to the values they had just before that interrupt was acknowledged. `eoi_pulse` is then high for one cycle, with `eoi_id` equal to the ID.
- R7: A completion write while the running ID is 1023, or for an ID other than the running one, changes nothing and gives no strobe.
- R8: Word 5 reads the running priority and word 6 reads the offered ID, both zero-extended.
- R9: Words 0x34 to 0x37 (byte offsets 0xD0 to 0xDC) form a 128-bit active-group vector. Word k holds bits 32k to 32k+31. Bit g is set while an acknowledged, not yet completed interrupt has priority bits 7:1 equal to g. Writes to these words are ignored.
- R10: A request to a word not listed in R2 to R9 gets read data 0 and `rsp_err` high, and changes nothing. A mapped word accessed in the direction it does not support gets read data 0 without error.
- R11: Every cycle with `bus_valid` high gives `rsp_valid` high in the next cycle, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Word index |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response one cycle after request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_err | output | 1 | Unmapped word accessed |
| sel_id | input | 10 | Highest-pending ID from the selector |
| sel_prio | input | 8 | Priority of `sel_id` |
| ack_pulse | output | 1 | Acknowledge taken |
| ack_id | output | 10 | ID acknowledged |
| eoi_pulse | output | 1 | Completion applied |
| eoi_id | output | 10 | ID completed |
| run_id | output | 10 | Running interrupt ID |
| run_prio | output | 8 | Running priority |
| prio_mask | output | 8 | Priority mask register |
| bin_point | output | 3 | Binary point register |
| alias_bin_point | output | 3 | Aliased binary point register |

## Verification
The acknowledge path is tried with offered priorities below, equal to and above the running one. An equal priority tells a strict comparison apart from a non-strict one. Offered IDs of 1023 and of NUM_IRQ or above show that each refusal cause works on its own. Chains of nested acknowledges followed by completions, in the right order, in the wrong order and with nothing running, show whether the restore path unwinds exactly one level and leaves everything else alone. A second instance at revision 1 gets the same aliased binary point writes, to tell the revision gating apart from a plain register.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

  localparam int ID_W      = 10;
  localparam int PRIO_W    = 8;
  localparam int DATA_W    = 32;
  localparam int APR_WORDS = 4;
  localparam int APR_BITS  = APR_WORDS * DATA_W;
  localparam int GROUP_W   = PRIO_W - 1;

  localparam logic [ID_W-1:0]   NO_IRQ    = 10'd1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

  // word indices on the bus
  localparam int W_PMR  = 1;
  localparam int W_BPR  = 2;
  localparam int W_ACK  = 3;
  localparam int W_EOI  = 4;
  localparam int W_RPR  = 5;
  localparam int W_HPP  = 6;
  localparam int W_ABPR = 7;
  localparam int W_APR0 = 52;

  typedef enum logic [3:0] {
    REG_NONE,
    REG_PMR,
    REG_BPR,
    REG_ACK,
    REG_EOI,
    REG_RPR,
    REG_HPP,
    REG_ABPR,
    REG_APR
  } reg_sel_e;

  // an offered interrupt may be claimed only when strictly more urgent
  function automatic logic ack_allowed(input logic [ID_W-1:0]   id,
                                       input logic [PRIO_W-1:0] prio,
                                       input logic [PRIO_W-1:0] running,
                                       input int                num_irq);
    return (id != NO_IRQ) && (int'(id) < num_irq) && (prio < running);
  endfunction

  function automatic logic [GROUP_W-1:0] prio_group(input logic [PRIO_W-1:0] prio);
    return prio[PRIO_W-1:1];
  endfunction

  function automatic logic [DATA_W-1:0] zext_id(input logic [ID_W-1:0] id);
    return {{(DATA_W-ID_W){1'b0}}, id};
  endfunction

endpackage

// File: rtl/cpuif_decode.sv
module cpuif_decode
  import cpuif_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [1:0]        apr_idx
);

  localparam int APR_LAST = W_APR0 + APR_WORDS - 1;

  always_comb begin
    sel     = REG_NONE;
    apr_idx = addr[1:0];
    if (int'(addr) >= W_APR0 && int'(addr) <= APR_LAST) begin
      sel = REG_APR;
    end else begin
      case (int'(addr))
        W_PMR:   sel = REG_PMR;
        W_BPR:   sel = REG_BPR;
        W_ACK:   sel = REG_ACK;
        W_EOI:   sel = REG_EOI;
        W_RPR:   sel = REG_RPR;
        W_HPP:   sel = REG_HPP;
        W_ABPR:  sel = REG_ABPR;
        default: sel = REG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/cpuif_active_ctl.sv
module cpuif_active_ctl
  import cpuif_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ack_req,
  input  logic [ID_W-1:0]     ack_cand_id,
  input  logic [PRIO_W-1:0]   ack_cand_prio,
  input  logic                eoi_req,
  input  logic [ID_W-1:0]     eoi_req_id,
  output logic                ack_ok,
  output logic                eoi_hit,
  output logic [ID_W-1:0]     run_id,
  output logic [PRIO_W-1:0]   run_prio,
  output logic [APR_BITS-1:0] apr_vec
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [ID_W-1:0]   prev_id   [NUM_IRQ];
  logic [PRIO_W-1:0] prev_prio [NUM_IRQ];
  logic [PRIO_W-1:0] own_prio  [NUM_IRQ];
  logic [NUM_IRQ-1:0] active_q;

  logic [IDX_W-1:0] ack_idx;
  logic [IDX_W-1:0] eoi_idx;

  assign ack_idx = ack_cand_id[IDX_W-1:0];
  assign eoi_idx = eoi_req_id[IDX_W-1:0];

  assign ack_ok  = ack_req && ack_allowed(ack_cand_id, ack_cand_prio, run_prio, NUM_IRQ);
  assign eoi_hit = eoi_req && (run_id != NO_IRQ) && (eoi_req_id == run_id);

  // running state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_id   <= NO_IRQ;
      run_prio <= IDLE_PRIO;
    end else if (ack_ok) begin
      run_id   <= ack_cand_id;
      run_prio <= ack_cand_prio;
    end else if (eoi_hit) begin
      run_id   <= prev_id[eoi_idx];
      run_prio <= prev_prio[eoi_idx];
    end
  end

  // per-interrupt link to the interrupt it preempted
  always_ff @(posedge clk) begin
    if (ack_ok) begin
      prev_id[ack_idx]   <= run_id;
      prev_prio[ack_idx] <= run_prio;
      own_prio[ack_idx]  <= ack_cand_prio;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (ack_ok) begin
      active_q[ack_idx] <= 1'b1;
    end else if (eoi_hit) begin
      active_q[eoi_idx] <= 1'b0;
    end
  end

  // active priority groups
  always_comb begin
    apr_vec = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (active_q[i]) begin
        apr_vec[prio_group(own_prio[i])] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_cpu_iface.sv
module irq_cpu_iface
  import cpuif_pkg::*;
#(
  parameter int REVISION = 2,
  parameter int NUM_IRQ  = 64,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic [9:0]        sel_id,
  input  logic [7:0]        sel_prio,
  output logic              ack_pulse,
  output logic [9:0]        ack_id,
  output logic              eoi_pulse,
  output logic [9:0]        eoi_id,
  output logic [9:0]        run_id,
  output logic [7:0]        run_prio,
  output logic [7:0]        prio_mask,
  output logic [2:0]        bin_point,
  output logic [2:0]        alias_bin_point
);

  localparam int BP_W = 3;

  reg_sel_e            reg_sel;
  logic [1:0]          apr_idx;
  logic                rd_req;
  logic                wr_req;
  logic                ack_req;
  logic                eoi_req;
  logic                ack_ok;
  logic                eoi_hit;
  logic                dec_err;
  logic [APR_BITS-1:0] apr_vec;
  logic [DATA_W-1:0]   rd_val;

  cpuif_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .sel     (reg_sel),
    .apr_idx (apr_idx)
  );

  assign rd_req  = bus_valid && !bus_write;
  assign wr_req  = bus_valid && bus_write;
  assign ack_req = rd_req && (reg_sel == REG_ACK);
  assign eoi_req = wr_req && (reg_sel == REG_EOI);
  assign dec_err = bus_valid && (reg_sel == REG_NONE);

  cpuif_active_ctl #(.NUM_IRQ(NUM_IRQ)) u_act (
    .clk           (clk),
    .rst_n         (rst_n),
    .ack_req       (ack_req),
    .ack_cand_id   (sel_id),
    .ack_cand_prio (sel_prio),
    .eoi_req       (eoi_req),
    .eoi_req_id    (bus_wdata[ID_W-1:0]),
    .ack_ok        (ack_ok),
    .eoi_hit       (eoi_hit),
    .run_id        (run_id),
    .run_prio      (run_prio),
    .apr_vec       (apr_vec)
  );

  // software-owned registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_mask <= '0;
      bin_point <= '0;
    end else if (wr_req) begin
      if (reg_sel == REG_PMR) prio_mask <= bus_wdata[PRIO_W-1:0];
      if (reg_sel == REG_BPR) bin_point <= bus_wdata[BP_W-1:0];
    end
  end

  generate
    if (REVISION >= 2) begin : g_abpr
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          alias_bin_point <= '0;
        end else if (wr_req && reg_sel == REG_ABPR) begin
          alias_bin_point <= bus_wdata[BP_W-1:0];
        end
      end
    end else begin : g_no_abpr
      assign alias_bin_point = '0;
    end
  endgenerate

  // read data
  always_comb begin
    rd_val = '0;
    case (reg_sel)
      REG_PMR:  rd_val = {{(DATA_W-PRIO_W){1'b0}}, prio_mask};
      REG_BPR:  rd_val = {{(DATA_W-BP_W){1'b0}}, bin_point};
      REG_ACK:  rd_val = ack_ok ? zext_id(sel_id) : zext_id(NO_IRQ);
      REG_RPR:  rd_val = {{(DATA_W-PRIO_W){1'b0}}, run_prio};
      REG_HPP:  rd_val = zext_id(sel_id);
      REG_ABPR: rd_val = {{(DATA_W-BP_W){1'b0}}, alias_bin_point};
      REG_APR:  rd_val = apr_vec[apr_idx*DATA_W +: DATA_W];
      default:  rd_val = '0;
    endcase
  end

  // response and strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      ack_pulse <= 1'b0;
      ack_id    <= NO_IRQ;
      eoi_pulse <= 1'b0;
      eoi_id    <= NO_IRQ;
    end else begin
      rsp_valid <= bus_valid;
      rsp_err   <= dec_err;
      rsp_rdata <= (rd_req && !dec_err) ? rd_val : '0;
      ack_pulse <= ack_ok;
      eoi_pulse <= eoi_hit;
      if (ack_ok)  ack_id <= sel_id;
      if (eoi_hit) eoi_id <= bus_wdata[ID_W-1:0];
    end
  end

endmodule

// File: rtl/cpuif_checker.sv
module cpuif_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_valid,
  input logic         bus_write,
  input logic [5:0]   bus_addr,
  input logic         rsp_valid,
  input logic [31:0]  rsp_rdata,
  input logic         rsp_err,
  input logic [7:0]   sel_prio,
  input logic         ack_pulse,
  input logic [9:0]   ack_id,
  input logic         eoi_pulse,
  input logic [9:0]   eoi_id,
  input logic [9:0]   run_id,
  input logic [7:0]   run_prio,
  input logic [127:0] apr_vec
);

  p_idle_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == 10'd1023) |-> (run_prio == 8'hFF));

  p_ack_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == 6'd3 && sel_prio >= run_prio)
      |=> (!ack_pulse && rsp_rdata == 32'd1023));

  p_ack_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> (run_id == ack_id && rsp_rdata == {22'd0, ack_id}));

  p_eoi_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pulse && $past(rst_n)) |-> (eoi_id == $past(run_id)));

  p_eoi_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == 6'd4 && run_id == 10'd1023)
      |=> (!eoi_pulse && run_id == 10'd1023));

  p_apr_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr >= 6'd52 && bus_addr <= 6'd55)
      |=> (apr_vec == $past(apr_vec)));

  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));

  p_rsp_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> rsp_valid);

  p_rsp_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !rsp_valid);

endmodule

bind irq_cpu_iface cpuif_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .sel_prio  (sel_prio),
  .ack_pulse (ack_pulse),
  .ack_id    (ack_id),
  .eoi_pulse (eoi_pulse),
  .eoi_id    (eoi_id),
  .run_id    (run_id),
  .run_prio  (run_prio),
  .apr_vec   (apr_vec)
);

// File: tb/tb_irq_cpu_iface.sv
module tb_irq_cpu_iface;

  localparam int NIRQ = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [9:0]  sel_id = 10'd1023;
  logic [7:0]  sel_prio = 8'hFF;

  logic        rsp_valid, rsp_err, ack_pulse, eoi_pulse;
  logic [31:0] rsp_rdata;
  logic [9:0]  ack_id, eoi_id, run_id;
  logic [7:0]  run_prio, prio_mask;
  logic [2:0]  bin_point, alias_bin_point;

  logic        r1_valid, r1_err, r1_ack, r1_eoi;
  logic [31:0] r1_rdata;
  logic [9:0]  r1_ack_id, r1_eoi_id, r1_run_id;
  logic [7:0]  r1_run_prio, r1_pmr;
  logic [2:0]  r1_bpr, r1_abpr;

  always #2.5 clk = ~clk;

  irq_cpu_iface #(.REVISION(2), .NUM_IRQ(NIRQ)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .sel_id(sel_id), .sel_prio(sel_prio),
    .ack_pulse(ack_pulse), .ack_id(ack_id), .eoi_pulse(eoi_pulse), .eoi_id(eoi_id),
    .run_id(run_id), .run_prio(run_prio), .prio_mask(prio_mask),
    .bin_point(bin_point), .alias_bin_point(alias_bin_point));

  irq_cpu_iface #(.REVISION(1), .NUM_IRQ(NIRQ)) dut_r1 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(r1_valid),
    .rsp_rdata(r1_rdata), .rsp_err(r1_err), .sel_id(sel_id), .sel_prio(sel_prio),
    .ack_pulse(r1_ack), .ack_id(r1_ack_id), .eoi_pulse(r1_eoi), .eoi_id(r1_eoi_id),
    .run_id(r1_run_id), .run_prio(r1_run_prio), .prio_mask(r1_pmr),
    .bin_point(r1_bpr), .alias_bin_point(r1_abpr));

  int checks = 0;
  int errors = 0;

  // reference model state
  int         m_run_id = 1023;
  logic [7:0] m_run_prio = 8'hFF;
  logic [7:0] m_pmr = 0;
  logic [2:0] m_bpr = 0;
  logic [2:0] m_abpr = 0;
  int         m_prev_id [NIRQ];
  logic [7:0] m_prev_prio [NIRQ];
  logic [7:0] m_own_prio [NIRQ];
  bit         m_active [NIRQ];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit may_ack(input int id, input logic [7:0] p);
    if (id == 1023 || id >= NIRQ) return 1'b0;
    return p < m_run_prio;
  endfunction

  function automatic logic [31:0] apr_word(input int k);
    logic [127:0] v = '0;
    for (int i = 0; i < NIRQ; i++)
      if (m_active[i]) v[m_own_prio[i] >> 1] = 1'b1;
    return v[k*32 +: 32];
  endfunction

  function automatic bit mapped(input int w);
    return (w >= 1 && w <= 7) || (w >= 52 && w <= 55);
  endfunction

  task automatic access(input bit wr, input int w, input logic [31:0] wd,
                        input int sid, input logic [7:0] sp);
    logic [31:0] e_rd;
    bit          e_ack, e_eoi, e_err;
    string       tag;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = 6'(w); bus_wdata = wd;
    sel_id = 10'(sid); sel_prio = sp;
    e_rd = 0; e_ack = 0; e_eoi = 0; e_err = !mapped(w);
    tag = e_err ? "R10" : "R2";
    if (!wr && !e_err) begin
      case (w)
        1: begin e_rd = {24'd0, m_pmr}; tag = "R2"; end
        2: begin e_rd = {29'd0, m_bpr}; tag = "R2"; end
        3: begin
          e_ack = may_ack(sid, sp);
          e_rd  = e_ack ? 32'(sid) : 32'd1023;
          tag   = e_ack ? "R5" : "R4";
        end
        4: tag = "R10";
        5: begin e_rd = {24'd0, m_run_prio}; tag = "R8"; end
        6: begin e_rd = 32'(sid); tag = "R8"; end
        7: begin e_rd = {29'd0, m_abpr}; tag = "R3"; end
        default: begin e_rd = apr_word(w - 52); tag = "R9"; end
      endcase
    end else if (wr && w == 4) begin
      e_eoi = (m_run_id != 1023) && (int'(wd[9:0]) == m_run_id);
      tag = e_eoi ? "R6" : "R7";
    end else if (wr && w == 7) tag = "R3";
    else if (wr && w >= 52 && w <= 55) tag = "R9";
    @(posedge clk); #1;
    // model update
    if (e_ack) begin
      m_prev_id[sid] = m_run_id; m_prev_prio[sid] = m_run_prio;
      m_own_prio[sid] = sp; m_active[sid] = 1'b1;
      m_run_id = sid; m_run_prio = sp;
    end
    if (e_eoi) begin
      int id = m_run_id;
      m_active[id] = 1'b0;
      m_run_id = m_prev_id[id]; m_run_prio = m_prev_prio[id];
    end
    if (wr && w == 1) m_pmr = wd[7:0];
    if (wr && w == 2) m_bpr = wd[2:0];
    if (wr && w == 7) m_abpr = wd[2:0];
    check("R11", {31'd0, rsp_valid}, 32'd1);
    check(tag, rsp_rdata, e_rd);
    check("R10", {31'd0, rsp_err}, {31'd0, e_err});
    check("R5", {31'd0, ack_pulse}, {31'd0, e_ack});
    if (e_ack) check("R5", {22'd0, ack_id}, 32'(sid));
    check("R6", {31'd0, eoi_pulse}, {31'd0, e_eoi});
    if (e_eoi) check("R6", {22'd0, eoi_id}, {22'd0, wd[9:0]});
    check(tag, {22'd0, run_id}, 32'(m_run_id));
    check(tag, {24'd0, run_prio}, {24'd0, m_run_prio});
    check("R2", {24'd0, prio_mask}, {24'd0, m_pmr});
    check("R2", {29'd0, bin_point}, {29'd0, m_bpr});
    check("R3", {29'd0, alias_bin_point}, {29'd0, m_abpr});
    check("R3", {29'd0, r1_abpr}, 32'd0);
    @(negedge clk);
    bus_valid = 1'b0;
    #1;
    check("R11", {31'd0, rsp_valid}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < NIRQ; i++) begin
      m_active[i] = 0; m_prev_id[i] = 1023; m_prev_prio[i] = 8'hFF; m_own_prio[i] = 8'hFF;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", {22'd0, run_id}, 32'd1023);
    check("R1", {24'd0, run_prio}, 32'hFF);
    check("R1", {24'd0, prio_mask}, 32'd0);
    check("R1", {29'd0, bin_point}, 32'd0);
    check("R1", {29'd0, alias_bin_point}, 32'd0);
    check("R1", {30'd0, ack_pulse, eoi_pulse}, 32'd0);
    check("R11", {31'd0, rsp_valid}, 32'd0);

    // directed corners
    access(1, 1, 32'h0000_01A5, 1023, 8'hFF);   // R2 mask low byte
    access(0, 1, 0, 1023, 8'hFF);
    access(1, 2, 32'hFFFF_FFFF, 1023, 8'hFF);   // R2 binary point 3 bits
    access(0, 2, 0, 1023, 8'hFF);
    access(1, 7, 32'h0000_000D, 1023, 8'hFF);   // R3 alias: rev2 keeps 5
    access(0, 7, 0, 1023, 8'hFF);
    check("R3", r1_rdata, 32'd0);               // R3 rev1 reads 0
    access(0, 3, 0, 1023, 8'h10);               // R4 no interrupt
    access(0, 3, 0, 100, 8'h10);                // R4 ID beyond NUM_IRQ
    access(0, 3, 0, 5, 8'hFF);                  // R4 equal priority at idle
    access(0, 3, 0, 5, 8'h40);                  // R5 take 5
    access(0, 3, 0, 10, 8'h40);                 // R4 equal to running
    access(0, 3, 0, 9, 8'h20);                  // R5 nest 9
    access(0, 5, 0, 9, 8'h20);                  // R8 running priority
    access(0, 6, 0, 33, 8'h20);                 // R8 offered ID
    access(0, 52, 0, 1023, 8'hFF);              // R9 bit 16
    access(0, 53, 0, 1023, 8'hFF);              // R9 bit 32
    access(1, 53, 32'hFFFF_FFFF, 1023, 8'hFF);  // R9 write ignored
    access(0, 53, 0, 1023, 8'hFF);
    access(1, 4, 32'd5, 1023, 8'hFF);           // R7 not running ID
    access(1, 4, 32'hFFFF_FC09, 1023, 8'hFF);   // R6 only bits 9:0 used
    access(1, 4, 32'd5, 1023, 8'hFF);           // R6 back to idle
    access(1, 4, 32'd1023, 1023, 8'hFF);        // R7 idle completion
    access(1, 4, 32'd5, 1023, 8'hFF);           // R7 idle completion
    access(0, 0, 0, 1023, 8'hFF);               // R10 unmapped
    access(1, 40, 32'h55, 1023, 8'hFF);         // R10 unmapped write
    access(0, 4, 0, 1023, 8'hFF);               // R10 wrong direction
    access(1, 3, 32'd7, 7, 8'h01);              // R10 write to acknowledge

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int          op = $urandom_range(0, 99);
      int          sid = $urandom_range(0, NIRQ - 1);
      logic [7:0]  sp = 8'($urandom_range(0, 255));
      logic [31:0] wd = $urandom();
      if ($urandom_range(0, 9) == 0) sid = ($urandom_range(0, 1) == 1) ? 1023 : NIRQ + 3;
      if (sid < NIRQ && m_active[sid]) sid = 1023;
      if (op < 35)      access(0, 3, 0, sid, sp);
      else if (op < 60) begin
        if (m_run_id != 1023 && $urandom_range(0, 3) != 0) wd[9:0] = 10'(m_run_id);
        else wd[9:0] = 10'($urandom_range(0, NIRQ - 1));
        access(1, 4, wd, sid, sp);
      end
      else if (op < 70) access($urandom_range(0, 1) == 1, $urandom_range(1, 7), wd, sid, sp);
      else if (op < 85) access($urandom_range(0, 1) == 1, $urandom_range(52, 55), wd, sid, sp);
      else if (op < 92) access(0, $urandom_range(5, 6), 0, sid, sp);
      else              access($urandom_range(0, 1) == 1, $urandom_range(8, 51), wd, sid, sp);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule